// File: doc/BRIEF.md
# 8-bit Compare Timer with Waveform Output

An 8-bit counter with one compare channel that produces a waveform pin and two interrupt requests. The counter advances on "steps": a step is either a pulse on a prescaled tick input or a chosen edge of an external event pin. The external pin is first synchronised into the clock domain. A control register selects one of four counting behaviours:

- a plain wrapping counter;
- a counter that clears after matching the compare value;
- an up/down counter that drives a symmetric, glitch-free pulse-width waveform;
- a clear-on-match counter whose output toggles, which makes a programmable frequency source.

Software reaches the block through a flat register port with a combinational read path. The registers hold the count, the compare value, the control fields, two sticky event flags and their interrupt enables. In the up/down waveform mode, a new compare value waits in a shadow register and takes effect only when the count turns at its ceiling. Duty-cycle updates therefore never cut a period short.

Top module: `tmr8_cmp_pwm`

## Requirements
- R1: After reset, every register reads 0 and `wave_o`, `irq_ovf_o` and `irq_cmp_o` are low.
- R2: Control bits [3:2] pick the step source. 0 gives no steps, so the count holds. 1 uses `tick_i` as the step. 2 steps on a falling edge of `evt_pin_i`, and 3 steps on a rising edge. Each pin edge produces exactly one step, and the count changes at the third rising clock edge after the pin changes.
- R3: In mode 0 (control bits [1:0] = 0), each step adds one to the count, and the count wraps from 0xFF to 0. In modes 0, 1 and 3, a step taken while the count is 0xFF sets the overflow flag. In modes 0 and 1, `wave_o` is low.
- R4: In mode 1, a step taken while the count equals the active compare value loads 0, so one period lasts compare+1 steps. Any other step adds one.
- R5: In every mode, a step taken while the count equals the active compare value sets the compare flag (flag bit 1) on that same clock edge.
- R6: In mode 2, the count climbs to 0xFF and then falls to 0, reversing direction at each end: 0xFF goes to 0xFE, and 0 goes to 1. A step that takes the count from 1 to 0 while it is falling sets the overflow flag (flag bit 0).
- R7: In mode 2, after each step `wave_o` is high when the new count is below the active compare value, or when the active compare value is 0xFF. A compare value of 0 therefore keeps the output low, and 0xFF keeps it high.
- R8: Compare writes always update the value read back at address 1. In mode 2, the active compare value is loaded from that value only on a step taken at count 0xFF. In the other modes, a compare write takes effect at once.
- R9: Mode 3 counts as in R4, and `wave_o` toggles on every step that matches the compare value.
- R10: A write to the flag register clears each flag whose data bit is 1 and leaves the others alone. An event on the same edge wins over the clear. Flags set whether or not their interrupt is enabled.
- R11: `irq_ovf_o` is flag bit 0 gated by mask bit 0. `irq_cmp_o` is flag bit 1 gated by mask bit 1.
- R12: The register map is:
  - address 0: count. A write loads the count and overrides a step on the same edge.
  - address 1: compare value.
  - address 2: control. Mode is in bits [1:0] and step source in bits [3:2]; the other bits read 0.
  - address 3: flags.
  - address 4: mask.
  
  Addresses 5 to 7 read 0, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Prescaled step pulse, one clock wide |
| evt_pin_i | input | 1 | Asynchronous external event input |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| wave_o | output | 1 | Waveform output |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare-match interrupt request |

## Verification
Directed cases cover four situations, each of which separates a fault the random mix would rarely isolate:
- a short clear-on-compare period, which exposes an off-by-one in the reload;
- counting of synchronised rising and falling pin edges, which catches a wrong edge polarity or a double count;
- the compare extremes 0 and 0xFF in the up/down mode, which reveal any one-step spike;
- a duty-cycle write in the middle of a period, which must read back at once but leave the waveform alone until the turn at the ceiling.

Random segments then run each mode with a sparse tick or pin-edge steps. Compare writes, flag clears and count loads land at random moments. These segments separate the direction, wrap and flag-priority cases from one another. A reference model is compared with the output pins and with every register read.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    // counting behaviour, control bits [1:0]
    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_CLRCMP = 2'd1,
        MODE_PCPWM  = 2'd2,
        MODE_TOGGLE = 2'd3
    } tmr_mode_e;

    // step source, control bits [3:2]
    typedef enum logic [1:0] {
        CS_STOP     = 2'd0,
        CS_TICK     = 2'd1,
        CS_EXT_FALL = 2'd2,
        CS_EXT_RISE = 2'd3
    } tmr_csel_e;

    typedef struct packed {
        tmr_csel_e csel;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    localparam int unsigned A_COUNT = 0;
    localparam int unsigned A_CMP   = 1;
    localparam int unsigned A_CTRL  = 2;
    localparam int unsigned A_FLAG  = 3;
    localparam int unsigned A_MASK  = 4;

    localparam int unsigned NFLAG  = 2;
    localparam int unsigned FL_OVF = 0;
    localparam int unsigned FL_CMP = 1;

endpackage

// File: rtl/tmr8_step_src.sv
module tmr8_step_src
    import tmr8_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      pin_i,
    input  tmr_csel_e csel_i,
    output logic      step_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } src_st_t;

    src_st_t st_d, st_q;
    logic [SYNC_STAGES-1:0] sync_shift;
    logic pin_s;
    logic rise;
    logic fall;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            assign sync_shift = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        end else begin : g_single
            assign sync_shift = pin_i;
        end
    endgenerate

    assign pin_s = st_q.sync[SYNC_STAGES-1];
    assign rise  = pin_s & ~st_q.prev;
    assign fall  = ~pin_s & st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.sync = sync_shift;
        st_d.prev = pin_s;
    end

    always_comb begin
        unique case (csel_i)
            CS_TICK:     step_o = tick_i;
            CS_EXT_FALL: step_o = fall;
            CS_EXT_RISE: step_o = rise;
            default:     step_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a stopped source never steps
    p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csel_i == CS_STOP) |-> !step_o);

    // R2: one pin edge gives one step, never two in a row
    p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csel_i == CS_EXT_RISE && step_o) |=> !step_o);

endmodule

// File: rtl/tmr8_count_unit.sv
module tmr8_count_unit
    import tmr8_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  tmr_mode_e     mode_i,
    input  logic          cnt_wr_i,
    input  logic          cmp_wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] cmp_buf_o,
    output logic [DW-1:0] nxt_cnt_o,
    output logic [DW-1:0] nxt_cmp_o,
    output logic          ovf_evt_o,
    output logic          cmp_evt_o
);

    localparam logic [DW-1:0] CNT_MAX = '1;
    localparam logic [DW-1:0] CNT_MIN = '0;
    localparam logic [DW-1:0] ONE     = DW'(1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] cmp_buf;
        logic [DW-1:0] cmp_act;
        logic          dn;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic at_top;
    logic at_bot;
    logic hit_now;
    logic ovf;

    assign at_top  = (st_q.cnt == CNT_MAX);
    assign at_bot  = (st_q.cnt == CNT_MIN);
    assign hit_now = (st_q.cnt == st_q.cmp_act);

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (step_i) begin
            unique case (mode_i)
                MODE_PCPWM: begin
                    if (!st_q.dn) begin
                        if (at_top) begin
                            st_d.cnt = CNT_MAX - ONE;
                            st_d.dn  = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else begin
                        if (at_bot) begin
                            st_d.cnt = ONE;
                            st_d.dn  = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                    ovf = st_q.dn && (st_q.cnt == ONE);
                    if (at_top) begin
                        st_d.cmp_act = st_q.cmp_buf;
                    end
                end
                MODE_CLRCMP, MODE_TOGGLE: begin
                    st_d.cnt = hit_now ? CNT_MIN : st_q.cnt + ONE;
                    ovf      = at_top;
                end
                default: begin
                    st_d.cnt = st_q.cnt + ONE;
                    ovf      = at_top;
                end
            endcase
        end
        if (mode_i != MODE_PCPWM) begin
            st_d.dn = 1'b0;
        end
        if (cmp_wr_i) begin
            st_d.cmp_buf = wdata_i;
            if (mode_i != MODE_PCPWM) begin
                st_d.cmp_act = wdata_i;
            end
        end
        if (cnt_wr_i) begin
            st_d.cnt = wdata_i;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign cmp_buf_o = st_q.cmp_buf;
    assign nxt_cnt_o = st_d.cnt;
    assign nxt_cmp_o = st_d.cmp_act;
    assign ovf_evt_o = ovf;
    assign cmp_evt_o = step_i && hit_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_free_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == MODE_FREE && !cnt_wr_i) |=> (cnt_o == $past(cnt_o) + ONE));

    p_ctc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == MODE_CLRCMP && !cnt_wr_i && st_q.cnt == st_q.cmp_act)
        |=> (st_q.cnt == CNT_MIN));

    p_pwm_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == MODE_PCPWM && !cnt_wr_i && at_top && !st_q.dn)
        |=> (st_q.cnt == CNT_MAX - ONE && st_q.dn));

    p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PCPWM && !(step_i && at_top)) |=> $stable(st_q.cmp_act));

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  tmr_mode_e     mode_i,
    input  logic          hit_i,
    input  logic [DW-1:0] nxt_cnt_i,
    input  logic [DW-1:0] nxt_cmp_i,
    output logic          wave_o
);

    localparam logic [DW-1:0] CMP_FULL = '1;
    localparam logic [DW-1:0] CMP_NONE = '0;

    typedef struct packed {
        logic wave;
    } wave_st_t;

    wave_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode_i)
            MODE_PCPWM: begin
                if (step_i) begin
                    st_d.wave = (nxt_cmp_i == CMP_FULL) || (nxt_cnt_i < nxt_cmp_i);
                end
            end
            MODE_TOGGLE: begin
                if (step_i && hit_i) begin
                    st_d.wave = ~st_q.wave;
                end
            end
            default: begin
                st_d.wave = 1'b0;
            end
        endcase
    end

    assign wave_o = st_q.wave;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == MODE_PCPWM && nxt_cmp_i == CMP_NONE) |=> !wave_o);

    p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == MODE_PCPWM && nxt_cmp_i == CMP_FULL) |=> wave_o);

    p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == MODE_TOGGLE && hit_i) |=> (wave_o != $past(wave_o)));

endmodule

// File: rtl/tmr8_cmp_pwm.sv
module tmr8_cmp_pwm
    import tmr8_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned AW          = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          evt_pin_i,
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          wave_o,
    output logic          irq_ovf_o,
    output logic          irq_cmp_o
);

    localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [NFLAG-1:0] flag;
        logic [NFLAG-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;

    logic sel_cnt, sel_cmp, sel_ctrl, sel_flag, sel_mask;
    logic step;
    logic ovf_evt;
    logic cmp_evt;
    logic [DW-1:0] cnt;
    logic [DW-1:0] cmp_buf;
    logic [DW-1:0] nxt_cnt;
    logic [DW-1:0] nxt_cmp;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;

    assign sel_cnt  = (reg_addr_i == AW'(A_COUNT));
    assign sel_cmp  = (reg_addr_i == AW'(A_CMP));
    assign sel_ctrl = (reg_addr_i == AW'(A_CTRL));
    assign sel_flag = (reg_addr_i == AW'(A_FLAG));
    assign sel_mask = (reg_addr_i == AW'(A_MASK));

    tmr8_step_src #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .pin_i  (evt_pin_i),
        .csel_i (regs_q.ctrl.csel),
        .step_o (step)
    );

    tmr8_count_unit #(
        .DW(DW)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .mode_i    (regs_q.ctrl.mode),
        .cnt_wr_i  (reg_wr_i && sel_cnt),
        .cmp_wr_i  (reg_wr_i && sel_cmp),
        .wdata_i   (reg_wdata_i),
        .cnt_o     (cnt),
        .cmp_buf_o (cmp_buf),
        .nxt_cnt_o (nxt_cnt),
        .nxt_cmp_o (nxt_cmp),
        .ovf_evt_o (ovf_evt),
        .cmp_evt_o (cmp_evt)
    );

    tmr8_wave #(
        .DW(DW)
    ) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .mode_i    (regs_q.ctrl.mode),
        .hit_i     (cmp_evt),
        .nxt_cnt_i (nxt_cnt),
        .nxt_cmp_i (nxt_cmp),
        .wave_o    (wave_o)
    );

    always_comb begin
        regs_d           = regs_q;
        flag_set         = '0;
        flag_set[FL_OVF] = ovf_evt;
        flag_set[FL_CMP] = cmp_evt;
        flag_clr         = (reg_wr_i && sel_flag) ? reg_wdata_i[NFLAG-1:0] : '0;
        regs_d.flag      = (regs_q.flag & ~flag_clr) | flag_set;
        if (reg_wr_i && sel_ctrl) begin
            regs_d.ctrl = tmr_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
        end
        if (reg_wr_i && sel_mask) begin
            regs_d.mask = reg_wdata_i[NFLAG-1:0];
        end
    end

    always_comb begin
        if (sel_cnt) begin
            reg_rdata_o = cnt;
        end else if (sel_cmp) begin
            reg_rdata_o = cmp_buf;
        end else if (sel_ctrl) begin
            reg_rdata_o = DW'(regs_q.ctrl);
        end else if (sel_flag) begin
            reg_rdata_o = DW'(regs_q.flag);
        end else if (sel_mask) begin
            reg_rdata_o = DW'(regs_q.mask);
        end else begin
            reg_rdata_o = '0;
        end
    end

    assign irq_ovf_o = regs_q.flag[FL_OVF] & regs_q.mask[FL_OVF];
    assign irq_cmp_o = regs_q.flag[FL_CMP] & regs_q.mask[FL_CMP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.flag[FL_OVF] && !(reg_wr_i && sel_flag && reg_wdata_i[FL_OVF]))
        |=> regs_q.flag[FL_OVF]);

    p_cmp_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> regs_q.flag[FL_CMP]);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovf_o || irq_cmp_o) |-> (regs_q.mask != '0));

endmodule

// File: tb/tb_tmr8_cmp_pwm.sv
module tb_tmr8_cmp_pwm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       evt_pin_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       wave_o;
    logic       irq_ovf_o;
    logic       irq_cmp_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_cnt, m_buf, m_act;
    logic       m_dn, m_wave;
    logic [1:0] m_flag, m_mask, m_mode, m_csel;
    logic       m_s1, m_s2, m_prev;
    logic       pin_lv;
    logic [7:0] last_rd;
    logic       last_wave, last_icmp;

    always #4 clk = ~clk;

    tmr8_cmp_pwm dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .evt_pin_i   (evt_pin_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .wave_o      (wave_o),
        .irq_ovf_o   (irq_ovf_o),
        .irq_cmp_o   (irq_cmp_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_cnt;
            3'd1:    return m_buf;
            3'd2:    return {4'b0, m_csel, m_mode};
            3'd3:    return {6'b0, m_flag};
            3'd4:    return {6'b0, m_mask};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        if (a == 3'd0) begin
            case (m_mode)
                2'd0:    return "R3 count";
                2'd1:    return "R4 count";
                2'd2:    return "R6 count";
                default: return "R9 count";
            endcase
        end
        if (a == 3'd1) return "R8 compare readback";
        if (a == 3'd3) return "R10 flags";
        return "R12 register read";
    endfunction

    function automatic string wave_tag();
        if (m_mode == 2'd2) return "R7 wave";
        if (m_mode == 2'd3) return "R9 wave";
        return "R3 wave low";
    endfunction

    task automatic m_advance(input logic tk, input logic pin, input logic wr,
                             input logic [2:0] a, input logic [7:0] wd);
        logic       stp, hit, ovf;
        logic [7:0] n_cnt, n_act, n_buf;
        logic       n_dn, n_wave;
        logic [1:0] clr;
        case (m_csel)
            2'd1:    stp = tk;
            2'd2:    stp = !m_s2 && m_prev;
            2'd3:    stp = m_s2 && !m_prev;
            default: stp = 1'b0;
        endcase
        n_cnt = m_cnt; n_act = m_act; n_buf = m_buf; n_dn = m_dn;
        hit = 1'b0; ovf = 1'b0;
        if (stp) begin
            hit = (m_cnt == m_act);
            if (m_mode == 2'd2) begin
                if (!m_dn) begin
                    if (m_cnt == 8'hFF) begin n_cnt = 8'hFE; n_dn = 1'b1; end
                    else n_cnt = m_cnt + 8'd1;
                end else begin
                    if (m_cnt == 8'h00) begin n_cnt = 8'h01; n_dn = 1'b0; end
                    else n_cnt = m_cnt - 8'd1;
                end
                ovf = m_dn && (m_cnt == 8'h01);
                if (m_cnt == 8'hFF) n_act = m_buf;
            end else begin
                ovf   = (m_cnt == 8'hFF);
                n_cnt = (m_mode != 2'd0 && hit) ? 8'h00 : m_cnt + 8'd1;
            end
        end
        if (m_mode != 2'd2) n_dn = 1'b0;
        if (wr && a == 3'd1) begin
            n_buf = wd;
            if (m_mode != 2'd2) n_act = wd;
        end
        if (wr && a == 3'd0) n_cnt = wd;
        case (m_mode)
            2'd2:    n_wave = stp ? ((n_act == 8'hFF) || (n_cnt < n_act)) : m_wave;
            2'd3:    n_wave = (stp && hit) ? ~m_wave : m_wave;
            default: n_wave = 1'b0;
        endcase
        clr    = (wr && a == 3'd3) ? wd[1:0] : 2'b00;
        m_flag = (m_flag & ~clr) | {hit, ovf};
        if (wr && a == 3'd2) begin m_mode = wd[1:0]; m_csel = wd[3:2]; end
        if (wr && a == 3'd4) m_mask = wd[1:0];
        m_cnt = n_cnt; m_act = n_act; m_buf = n_buf; m_dn = n_dn; m_wave = n_wave;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    endtask

    task automatic run_cycle(input logic tk, input logic wr, input logic [2:0] a,
                             input logic [7:0] wd);
        @(negedge clk);
        tick_i = tk; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd; evt_pin_i = pin_lv;
        #1;
        last_rd = reg_rdata_o; last_wave = wave_o; last_icmp = irq_cmp_o;
        chk({31'b0, wave_o}, {31'b0, m_wave}, wave_tag());
        chk({31'b0, irq_ovf_o}, {31'b0, m_flag[0] & m_mask[0]}, "R11 overflow irq");
        chk({31'b0, irq_cmp_o}, {31'b0, m_flag[1] & m_mask[1]}, "R11 compare irq");
        if (!wr) chk({24'b0, reg_rdata_o}, {24'b0, m_read(a)}, read_tag(a));
        m_advance(tk, pin_lv, wr, a, wd);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] wd);
        run_cycle(1'b0, 1'b1, a, wd);
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [7:0] exp, input string tag);
        run_cycle(1'b0, 1'b0, a, 8'h00);
        chk({24'b0, last_rd}, {24'b0, exp}, tag);
    endtask

    task automatic pin_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            pin_lv = 1'b1;
            for (int j = 0; j < 3; j++) run_cycle(1'($urandom % 2), 1'b0, 3'd0, 8'h00);
            pin_lv = 1'b0;
            for (int j = 0; j < 3; j++) run_cycle(1'($urandom % 2), 1'b0, 3'd0, 8'h00);
        end
        for (int j = 0; j < 4; j++) run_cycle(1'b0, 1'b0, 3'd0, 8'h00);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;
        void'($urandom(32'd20240611));
        m_cnt = '0; m_buf = '0; m_act = '0; m_dn = 1'b0; m_wave = 1'b0;
        m_flag = '0; m_mask = '0; m_mode = '0; m_csel = '0;
        m_s1 = 1'b0; m_s2 = 1'b0; m_prev = 1'b0; pin_lv = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) rd_exp(3'(a), 8'h00, "R1 reset register");
        chk({31'b0, last_wave}, 32'd0, "R1 reset wave");
        chk({31'b0, last_icmp}, 32'd0, "R1 reset irq");

        // R4/R5/R11/R12: short clear-on-compare period
        wr_reg(3'd4, 8'h03);
        wr_reg(3'd1, 8'h03);
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd2, 8'h05);
        for (int i = 0; i < 4; i++) run_cycle(1'b1, 1'b0, 3'd0, 8'h00);
        rd_exp(3'd0, 8'h00, "R4 period of compare+1");
        rd_exp(3'd3, 8'h02, "R5 compare flag set");
        chk({31'b0, last_icmp}, 32'd1, "R11 compare irq raised");
        rd_exp(3'd2, 8'h05, "R12 control readback");
        rd_exp(3'd6, 8'h00, "R12 unmapped address");
        wr_reg(3'd3, 8'h02);
        rd_exp(3'd3, 8'h00, "R10 write-one clear");

        // R2: stopped source
        wr_reg(3'd2, 8'h01);
        for (int i = 0; i < 10; i++) run_cycle(1'b1, 1'b0, 3'd0, 8'h00);
        rd_exp(3'd0, 8'h00, "R2 stopped count holds");

        // R2: external rising then falling edges
        wr_reg(3'd2, 8'h0C);
        wr_reg(3'd0, 8'h00);
        pin_pulses(5);
        rd_exp(3'd0, 8'h05, "R2 rising edges counted");
        wr_reg(3'd2, 8'h08);
        wr_reg(3'd0, 8'h00);
        pin_pulses(5);
        rd_exp(3'd0, 8'h05, "R2 falling edges counted");

        // R7: compare 0 keeps output low
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd2, 8'h06);
        lows = 0;
        for (int i = 0; i < 600; i++) begin
            run_cycle(1'b1, 1'b0, 3'd0, 8'h00);
            if (last_wave) lows++;
        end
        chk(32'(lows), 32'd0, "R7 compare 0 never high");

        // R7: compare 0xFF keeps output high
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd1, 8'hFF);
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd2, 8'h06);
        lows = 0;
        for (int i = 0; i < 600; i++) begin
            run_cycle(1'b1, 1'b0, 3'd0, 8'h00);
            if (i > 0 && !last_wave) lows++;
        end
        chk(32'(lows), 32'd0, "R7 compare FF never low");

        // R8: buffered compare write mid-period
        wr_reg(3'd1, 8'h20);
        rd_exp(3'd1, 8'h20, "R8 buffer readback");
        chk({31'b0, last_wave}, 32'd1, "R8 old duty kept before top");
        for (int i = 0; i < 600; i++) run_cycle(1'b1, 1'b0, 3'd0, 8'h00);

        // random segments, one mode per segment in rotation
        for (int seg = 0; seg < 12; seg++) begin
            logic [1:0] cs;
            cs = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd1;
            wr_reg(3'd2, {4'b0, cs, 2'(seg % 4)});
            wr_reg(3'd1, ($urandom % 2) ? 8'($urandom % 24) : 8'($urandom));
            wr_reg(3'd4, 8'($urandom % 4));
            for (int i = 0; i < 1500; i++) begin
                int r;
                logic tk;
                r  = $urandom % 200;
                tk = ($urandom % 3) != 0;
                if ($urandom % 4 == 0) pin_lv = ~pin_lv;
                if (r < 3) run_cycle(tk, 1'b1, 3'd1, ($urandom % 2) ? 8'($urandom % 24) : 8'($urandom));
                else if (r < 6) run_cycle(tk, 1'b1, 3'd3, 8'($urandom % 4));
                else if (r == 6) run_cycle(tk, 1'b1, 3'd0, 8'($urandom));
                else run_cycle(tk, 1'b0, 3'($urandom % 8), 8'h00);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule